// File: doc/BRIEF.md
# Windowed Measurement Averager

This block takes signed sample values, one for each of three quantities (power, voltage and current). It adds up the samples of the selected quantity over a window of 2^N milliseconds. At the end of each window it divides the sum by the number of samples, limits the quotient to a signed count of -256..+256 and loads it into a 16-bit output word. It raises a one-cycle `new_data` strobe in the same cycle. Samples are counted on a sample strobe. A configuration bit chooses whether the strobe comes from the internal sample clock or from an external one. The number of samples per millisecond is a power of two (`LOG2_MS`, 1024 samples per millisecond by default), so the divide is a shift.

The 8-bit configuration byte is written with `cfg_wr`. It goes into a pending copy, and that copy becomes active only when the window in progress ends. When the block is in shutdown, no window is running and a new configuration takes effect one cycle after it is written. The window state machine has three states:
- ACCUM adds samples. It moves to LOAD on the strobe that completes the window.
- LOAD writes the output word and makes the pending configuration active. It moves to HALT if the pending configuration requests shutdown, and to ACCUM otherwise.
- HALT idles with the sum cleared. It moves to ACCUM once the pending configuration no longer requests shutdown.

A strobe that arrives during the single LOAD cycle is dropped, so the strobes must be at least two cycles apart.

Top module: `meas_avg`

## Requirements
- R1: After reset, `dout` is 0x0000, `new_data` is low, and the active configuration is all zeros: power selected, N=0, running, internal strobe.
- R2: The configuration byte has bits [3:0] = N, bit 4 = shutdown, bit 5 = external strobe and bits [7:6] = quantity. A window ends on exactly the (2^LOG2_MS)·2^N-th accepted strobe. An N above 8 is treated as 8.
- R3: The result is the window sum divided by the window's sample count, rounded toward zero.
- R4: A quotient above +256 is reported as +256, and one below -256 is reported as -256.
- R5: `dout` holds the signed count in bits [15:6] with bits [5:0] zero. +256 reads 0x4000 and -256 reads 0xC000.
- R6: The quantity field selects the sample input: 00 selects power, 01 voltage, 10 current, and 11 is treated as power. In voltage mode a negative result is reported as 0.
- R7: A configuration written during a window does not affect that window. It applies from the next window on.
- R8: While shutdown is active, strobes are not accumulated, `dout` holds its value and `new_data` stays low. Leaving shutdown starts a fresh window from a zero sum.
- R9: With bit 5 clear only `int_tick` counts as a sample strobe, and with bit 5 set only `ext_tick` counts.
- R10: `new_data` is high for exactly one cycle per load of `dout`, in the cycle in which the new value first appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Writes `cfg_data` into the pending configuration |
| cfg_data | input | 8 | Configuration byte (fields listed in R2) |
| int_tick | input | 1 | Sample strobe from the internal clock |
| ext_tick | input | 1 | Sample strobe from the external clock |
| sample_pwr | input | SAMPLE_W | Signed power sample |
| sample_volt | input | SAMPLE_W | Signed voltage sample |
| sample_cur | input | SAMPLE_W | Signed current sample |
| dout | output | 16 | Output word: count in [15:6], zeros in [5:0] |
| new_data | output | 1 | One-cycle strobe when `dout` is loaded |

## Verification
A sample counter that is off by one moves the load strobe one sample early or late. That error shows one cycle after the final strobe of the very first window. A corrupted sum or a wrong rounding bias shows only in the value of the next output word, so every window's word is compared against a sum kept by the bench. A configuration applied too early or left pending shows as a wrong quantity, window length or strobe source one window later. A state machine that fails to halt shows as a `new_data` strobe or a changed `dout` while shutdown is active.

// File: rtl/meas_avg_pkg.sv
package meas_avg_pkg;

    localparam int COUNT_W   = 10;   // signed count field, holds -256..+256
    localparam int PAD_W     = 6;    // zero bits below the count
    localparam int FULL_CNT  = 256;

    typedef enum logic [1:0] {
        MODE_PWR  = 2'b00,
        MODE_VOLT = 2'b01,
        MODE_CURR = 2'b10,
        MODE_ALT  = 2'b11
    } meas_mode_e;

    typedef struct packed {
        meas_mode_e mode;     // [7:6]
        logic       ext_clk;  // [5]
        logic       shdn;     // [4]
        logic [3:0] win;      // [3:0]
    } meas_cfg_t;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HALT  = 2'd2
    } win_state_e;

endpackage

// File: rtl/meas_win_fsm.sv
module meas_win_fsm
    import meas_avg_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 31,
    parameter int CNT_W    = 19,
    parameter int SH_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [SH_W-1:0]            win_sh,
    input  logic                       halt_req,
    output win_state_e                 state,
    output logic                       load,
    output logic signed [ACC_W-1:0]    acc
);

    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    win_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             final_tick;

    assign last_idx   = (ONE_C << win_sh) - ONE_C;
    assign final_tick = (state == ST_ACCUM) && tick && (cnt == last_idx);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACCUM: if (final_tick) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = halt_req ? ST_HALT : ST_ACCUM;
            ST_HALT:  state_nx = halt_req ? ST_HALT : ST_ACCUM;
            default:  state_nx = ST_ACCUM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACCUM;
        else        state <= state_nx;
    end

    // datapath: sum and sample count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (state == ST_ACCUM) begin
            if (tick) begin
                acc <= acc + {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
                cnt <= cnt + ONE_C;
            end
        end else begin
            acc <= '0;
            cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        load = (state == ST_LOAD);
    end

    // R2: the load cycle follows exactly 2^win_sh accepted samples
    p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt == last_idx + ONE_C));

    // R8: a halted window keeps a cleared sum and count
    p_halt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (cnt == '0 && acc == '0));

endmodule

// File: rtl/meas_result_fmt.sv
module meas_result_fmt
    import meas_avg_pkg::*;
#(
    parameter int ACC_W = 31,
    parameter int SH_W  = 5
) (
    input  logic signed [ACC_W-1:0] sum,
    input  logic [SH_W-1:0]         sh,
    input  logic                    clip_neg,
    output logic [15:0]             word
);

    localparam logic signed [ACC_W-1:0] ONE_A   = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(FULL_CNT);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(FULL_CNT);

    logic signed [ACC_W-1:0]   bias;
    logic signed [ACC_W-1:0]   adj;
    logic signed [ACC_W-1:0]   quo;
    logic signed [COUNT_W-1:0] cnt_q;

    always_comb begin
        // negative sums get 2^sh-1 added so the arithmetic shift truncates toward zero
        bias = sum[ACC_W-1] ? ((ONE_A << sh) - ONE_A) : '0;
        adj  = sum + bias;
        quo  = adj >>> sh;
        if (quo > POS_LIM)      cnt_q = COUNT_W'(FULL_CNT);
        else if (quo < NEG_LIM) cnt_q = -COUNT_W'(FULL_CNT);
        else                    cnt_q = quo[COUNT_W-1:0];
        if (clip_neg && cnt_q[COUNT_W-1]) cnt_q = '0;
        word = {cnt_q, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/meas_avg.sv
module meas_avg
    import meas_avg_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int LOG2_MS  = 10,
    parameter int NMAX     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [7:0]                 cfg_data,
    input  logic                       int_tick,
    input  logic                       ext_tick,
    input  logic signed [SAMPLE_W-1:0] sample_pwr,
    input  logic signed [SAMPLE_W-1:0] sample_volt,
    input  logic signed [SAMPLE_W-1:0] sample_cur,
    output logic [15:0]                dout,
    output logic                       new_data
);

    localparam int ACC_W = SAMPLE_W + LOG2_MS + NMAX + 1;
    localparam int CNT_W = LOG2_MS + NMAX + 1;
    localparam int SH_W  = $clog2(LOG2_MS + NMAX + 1);

    meas_cfg_t                 pend_cfg, act_cfg;
    win_state_e                state;
    logic                      load;
    logic signed [ACC_W-1:0]   acc;
    logic [3:0]                n_eff;
    logic [SH_W-1:0]           win_sh;
    logic                      tick;
    logic signed [SAMPLE_W-1:0] sample_sel;
    logic [15:0]               fmt_word;

    // configuration: pending copy, made active at a window boundary or while halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_cfg <= '0;
            act_cfg  <= '0;
        end else begin
            if (cfg_wr) pend_cfg <= meas_cfg_t'(cfg_data);
            if (load || state == ST_HALT) act_cfg <= pend_cfg;
        end
    end

    assign n_eff  = (act_cfg.win > 4'(NMAX)) ? 4'(NMAX) : act_cfg.win;
    assign win_sh = SH_W'(LOG2_MS) + SH_W'(n_eff);
    assign tick   = act_cfg.ext_clk ? ext_tick : int_tick;

    always_comb begin
        unique case (act_cfg.mode)
            MODE_VOLT: sample_sel = sample_volt;
            MODE_CURR: sample_sel = sample_cur;
            default:   sample_sel = sample_pwr;
        endcase
    end

    meas_win_fsm #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .CNT_W    (CNT_W),
        .SH_W     (SH_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sample   (sample_sel),
        .win_sh   (win_sh),
        .halt_req (pend_cfg.shdn),
        .state    (state),
        .load     (load),
        .acc      (acc)
    );

    meas_result_fmt #(
        .ACC_W (ACC_W),
        .SH_W  (SH_W)
    ) u_fmt (
        .sum      (acc),
        .sh       (win_sh),
        .clip_neg (act_cfg.mode == MODE_VOLT),
        .word     (fmt_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            new_data <= 1'b0;
        end else begin
            new_data <= load;
            if (load) dout <= fmt_word;
        end
    end

    // R10: the strobe never lasts two cycles
    p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |=> !new_data);

    // R8: the word only moves together with the strobe
    p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !new_data |-> $stable(dout));

    // R4: the count field stays within full scale
    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |-> ($signed(dout[15:6]) <= 10'sd256 && $signed(dout[15:6]) >= -10'sd256));

    // R5: low pad bits are zero
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        new_data |-> (dout[5:0] == 6'd0));

    // R7: a write during accumulation leaves the active configuration alone
    p_cfg_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && state == ST_ACCUM && !load) |=> (act_cfg == $past(act_cfg)));

    // R6: voltage results are never negative
    p_volt_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (new_data && $past(act_cfg.mode) == MODE_VOLT) |-> !dout[15]);

endmodule

// File: tb/tb_meas_avg.sv
`timescale 1ns/100ps
module tb_meas_avg;

    localparam int SW  = 12;
    localparam int LMS = 2;
    localparam int NMX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_data = '0;
    logic int_tick = 1'b0;
    logic ext_tick = 1'b0;
    logic signed [SW-1:0] s_pwr = '0;
    logic signed [SW-1:0] s_volt = '0;
    logic signed [SW-1:0] s_cur = '0;
    logic [15:0] dout;
    logic new_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_load = 0;
    bit done = 0;
    bit prev_nd = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];
    logic [15:0] exp_w;
    string exp_t;
    logic [7:0] cur_cfg = '0;

    meas_avg #(.SAMPLE_W(SW), .LOG2_MS(LMS), .NMAX(NMX)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .int_tick(int_tick), .ext_tick(ext_tick),
        .sample_pwr(s_pwr), .sample_volt(s_volt), .sample_cur(s_cur),
        .dout(dout), .new_data(new_data)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic finish_test();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int smp(input int base, input int seed, input int i);
        return base + ((i * 37 + seed) % 23) - 11;
    endfunction

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n) begin
            if (new_data) begin
                n_load++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R10 unexpected result", int'(dout), 0);
                end else begin
                    exp_w = exp_q.pop_front();
                    exp_t = tag_q.pop_front();
                    check(dout == exp_w, exp_t, int'(dout), int'(exp_w));
                end
            end
            if (prev_nd && new_data) check(1'b0, "R10 strobe longer than one cycle", 1, 0);
            prev_nd = new_data;
        end
    end

    // driver: one full window under cur_cfg, writes nxt halfway (R7)
    task automatic run_window(input logic [7:0] nxt, input int bp, input int bv,
                              input int bc, input string tag);
        int n, len, sum, avg, loads0, v;
        bit ext;
        n = int'(cur_cfg[3:0]);
        if (n > 8) n = 8;
        len = (1 << LMS) << n;
        ext = cur_cfg[5];
        sum = 0;
        for (int i = 0; i < len; i++) begin
            case (cur_cfg[7:6])
                2'b01:   v = smp(bv, 2, i);
                2'b10:   v = smp(bc, 3, i);
                default: v = smp(bp, 1, i);
            endcase
            sum += v;
        end
        avg = sum / len;
        if (avg > 256) avg = 256;
        if (avg < -256) avg = -256;
        if (cur_cfg[7:6] == 2'b01 && avg < 0) avg = 0;
        exp_q.push_back(16'(avg * 64));
        tag_q.push_back(tag);
        loads0 = n_load;
        for (int i = 0; i < len; i++) begin
            if (i == len - 1) check(n_load == loads0, "R2 no result before final sample", n_load - loads0, 0);
            s_pwr  = SW'(smp(bp, 1, i));
            s_volt = SW'(smp(bv, 2, i));
            s_cur  = SW'(smp(bc, 3, i));
            if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
            @(negedge clk);
            // the unselected strobe pulses as noise (R9)
            int_tick = ext;
            ext_tick = !ext;
            if (i == len / 2) begin
                cfg_wr = 1'b1;
                cfg_data = nxt;
            end
            @(negedge clk);
            int_tick = 1'b0;
            ext_tick = 1'b0;
            cfg_wr = 1'b0;
        end
        #1;
        check(n_load == loads0 + 1, "R2 one result right after final sample", n_load - loads0, 1);
        cur_cfg = nxt;
    endtask

    initial begin
        logic [15:0] held;
        int loads_h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(dout == 16'h0000, "R1 reset dout", int'(dout), 0);
        check(new_data == 1'b0, "R1 reset strobe", int'(new_data), 0);

        // R1 defaults: power, N=0
        run_window(8'h41, 40, 120, -30, "R1 R3 R6 default power window");
        run_window(8'h83, 40, 100, -30, "R6 R7 voltage N=1");
        run_window(8'h00, 40, 100, -3, "R3 R6 current N=3 rounds toward zero");
        run_window(8'h80, 1500, 100, -30, "R4 R5 power saturates to 0x4000");
        run_window(8'h40, 40, 100, -1500, "R4 R5 current saturates to 0xC000");
        run_window(8'hEF, 40, -50, -30, "R6 negative voltage reads zero");
        run_window(8'h02, 70, 300, -200, "R2 R6 R9 mode 11 as power, N clamped, external strobe");
        run_window(8'h12, -5, 100, 60, "R3 R9 power N=2 negative rounding");

        // R8: shutdown is now active
        held = dout;
        loads_h = n_load;
        for (int i = 0; i < 20; i++) begin
            s_pwr = SW'(900);
            int_tick = 1'b1;
            @(negedge clk);
            int_tick = 1'b0;
            @(negedge clk);
        end
        check(dout == held, "R8 dout held in shutdown", int'(dout), int'(held));
        check(n_load == loads_h, "R8 no result in shutdown", n_load - loads_h, 0);
        cfg_wr = 1'b1;
        cfg_data = 8'h02;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cur_cfg = 8'h02;
        run_window(8'h02, 25, 100, -30, "R8 fresh window after shutdown");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 every expected result seen", exp_q.size(), 0);
        finish_test();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            finish_test();
        end
    end

endmodule